// File: doc/BRIEF.md
# Oversampling Majority-Vote Line Bit Detector

This block turns the digital outputs of an external amplitude comparator into one decided line bit per 192 kHz bit period. It runs on a fast sampling clock of 7.68 MHz, which gives 40 cycles per bit. Inside each bit it opens a window of exactly 29 samples and counts the samples that show signal energy. A sample shows energy when either comparator output, positive or negative pulse, is high. If 16 or more of the 29 samples show energy, the bit is a logical 0. Otherwise it is a logical 1, meaning no signal.

The place of the window in the bit is set by an anchor pulse. When `fixed_bus` is 1, the receive timing is tied to the local transmit timing. The anchor is then the transmit bit-edge pulse, and the window opens 35 fast cycles after it, which rounds the required 4.6 µs shift. When `fixed_bus` is 0, the anchor is a bit-phase strobe that comes from an external clock-recovery circuit. The window then opens 5 cycles after that strobe, so the 29 samples sit near the middle of the bit. The decided bit is registered and is marked by a one-cycle valid pulse.

Top module: `majority_bit_slicer`

## Requirements
- R1: A synchronous active-high reset sets `bit_out` to 1, clears `bit_valid` and drops any window in progress. After reset, no valid pulse is issued until a complete window has been sampled after an anchor.
- R2: A sample counts as energy when `energy_pos` or `energy_neg` is 1 at the sampling edge. Either input alone is enough.
- R3: With 16 or more energy samples out of 29 the decided bit is 0. With 15 or fewer it is 1. Each window's count starts from zero.
- R4: A window takes exactly 29 samples on consecutive edges. Energy inputs outside a window have no effect on the decision.
- R5: When `fixed_bus` is 1, the first sample is taken at the edge 35 cycles after the edge that sees `tx_bit_edge` high. `bit_valid` is high in the cycle that follows the 29th sample edge.
- R6: When `fixed_bus` is 0, the first sample is taken at the edge 5 cycles after the edge that sees `rx_bit_strobe` high. `tx_bit_edge` is ignored in this mode.
- R7: When `fixed_bus` is 1, `rx_bit_strobe` is ignored.
- R8: `bit_valid` is a single-cycle pulse, issued once per completed window and never without a preceding anchor.
- R9: If a window start falls while a window is still open, the open window is dropped without a valid pulse. Its count is discarded, and a fresh 29-sample window begins at that start.
- R10: `bit_out` changes only in a cycle in which `bit_valid` is high, or on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock, 40 cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| fixed_bus | input | 1 | 1: window tied to transmit timing; 0: window tied to recovered bit phase |
| tx_bit_edge | input | 1 | One-cycle pulse at each transmit bit-clock edge |
| rx_bit_strobe | input | 1 | One-cycle recovered bit-phase pulse |
| energy_pos | input | 1 | Comparator output: positive pulse above half of the peak level |
| energy_neg | input | 1 | Comparator output: negative pulse above half of the peak level |
| bit_out | output | 1 | Decided bit, 0 = signal present |
| bit_valid | output | 1 | One-cycle strobe marking a new decision |

## Verification
The assertions assume that the anchor pulses are one cycle wide and that the comparator outputs are already synchronous to the fast clock. They also assume that `fixed_bus` does not change while a window is being placed. The stimulus drives all inputs on the falling edge. It changes the mode only between windows, after the anchor counter has gone idle, and it gives each window a single anchor. The only exceptions are deliberate pulses on the unselected anchor input and one intentional early restart.

// File: rtl/majority_bit_slicer.sv
module majority_bit_slicer #(
  parameter int PERIOD      = 40,
  parameter int SAMPLES     = 29,
  parameter int MAJORITY    = 16,
  parameter int FIXED_DELAY = 35,
  parameter int RECOV_DELAY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic fixed_bus,
  input  logic tx_bit_edge,
  input  logic rx_bit_strobe,
  input  logic energy_pos,
  input  logic energy_neg,
  output logic bit_out,
  output logic bit_valid
);
  localparam int LIM = (FIXED_DELAY > RECOV_DELAY) ? FIXED_DELAY : RECOV_DELAY;
  localparam int DW  = $clog2(LIM + 2);
  localparam int CW  = $clog2(SAMPLES + 1);
  localparam logic [DW-1:0] DLIM = DW'(LIM + 1);
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);
  localparam logic [CW:0]   MAJ  = (CW+1)'(MAJORITY);

  logic [DW-1:0] since;
  logic [CW-1:0] idx, cnt;
  logic          active;

  wire           anchor = fixed_bus ? tx_bit_edge : rx_bit_strobe;
  wire [DW-1:0]  target = fixed_bus ? DW'(FIXED_DELAY) : DW'(RECOV_DELAY);
  wire           start  = (since == target);
  wire           smp    = energy_pos | energy_neg;
  wire [CW:0]    total  = {1'b0, cnt} + (CW+1)'(smp);

  always_ff @(posedge clk) begin
    if (rst)
      since <= '0;
    else if (anchor)
      since <= DW'(1);
    else if (since != '0 && since < DLIM)
      since <= since + DW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      idx       <= '0;
      cnt       <= '0;
      bit_out   <= 1'b1;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (start) begin
        active <= 1'b1;
        idx    <= CW'(1);
        cnt    <= CW'(smp);
      end else if (active) begin
        cnt <= total[CW-1:0];
        idx <= idx + CW'(1);
        if (idx == LAST) begin
          active    <= 1'b0;
          bit_out   <= (total < MAJ);
          bit_valid <= 1'b1;
        end
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (bit_out && !bit_valid));

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  assert_valid_ends_window_R4: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> ($past(active) && !active));

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= idx));

  assert_bit_held_R10: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> (bit_valid || $stable(bit_out)));

endmodule

// File: tb/sim_majority_bit_slicer.sv
module sim_majority_bit_slicer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fixed_bus = 1'b1, tx_bit_edge = 1'b0, rx_bit_strobe = 1'b0;
  logic energy_pos = 1'b0, energy_neg = 1'b0;
  logic bit_out, bit_valid;
  int   errors = 0, checks = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  majority_bit_slicer u0 (
    .clk(clk), .rst(rst), .fixed_bus(fixed_bus), .tx_bit_edge(tx_bit_edge),
    .rx_bit_strobe(rx_bit_strobe), .energy_pos(energy_pos),
    .energy_neg(energy_neg), .bit_out(bit_out), .bit_valid(bit_valid));

  // {fixed_bus, use_pos, expected bit, 29 samples (bit 0 first)}
  localparam logic [31:0] VEC [7] = '{
    {1'b1, 1'b1, 1'b0, 29'h1FFFFFFF},
    {1'b1, 1'b0, 1'b1, 29'h00000000},
    {1'b0, 1'b0, 1'b0, 29'h0000FFFF},
    {1'b1, 1'b0, 1'b1, 29'h00007FFF},
    {1'b0, 1'b1, 1'b1, 29'h15555555},
    {1'b0, 1'b1, 1'b0, 29'h1FFFE000},
    {1'b1, 1'b1, 1'b1, 29'h1FFFC000}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic use_pos);
    energy_pos = use_pos ? v : 1'b0;
    energy_neg = use_pos ? 1'b0 : v;
  endtask

  task automatic run_window(input logic md, input logic use_pos,
                            input logic [28:0] pat, input logic expb);
    int off = md ? 35 : 5;
    int early = 0;
    @(negedge clk);
    fixed_bus = md;
    if (md) tx_bit_edge = 1'b1; else rx_bit_strobe = 1'b1;
    drive(expb, use_pos);
    for (int c = 1; c <= off + 28; c++) begin
      @(negedge clk);
      tx_bit_edge = 1'b0;
      rx_bit_strobe = 1'b0;
      if (c == off + 10) begin
        if (md) rx_bit_strobe = 1'b1; else tx_bit_edge = 1'b1;
      end
      if (bit_valid) early++;
      drive((c >= off) ? pat[c - off] : expb, use_pos);
    end
    @(negedge clk);
    tx_bit_edge = 1'b0;
    rx_bit_strobe = 1'b0;
    drive(expb, use_pos);
    chk(early == 0, "R5/R6/R7", "no early valid", early, 0);
    chk(bit_valid == 1'b1, md ? "R5" : "R6", "valid after 29th sample", bit_valid, 1);
    chk(bit_out == expb, "R3/R2/R4", "decided bit", bit_out, expb);
    @(negedge clk);
    chk(bit_valid == 1'b0, "R8", "valid one cycle", bit_valid, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    chk(bit_out == 1'b1, "R1", "bit_out in reset", bit_out, 1);
    chk(bit_valid == 1'b0, "R1", "valid in reset", bit_valid, 0);
    rst = 1'b0;

    // R8: no anchor, no valid, whatever the comparator shows
    seen = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      drive(c[0], c[1]);
      if (bit_valid) seen++;
    end
    chk(seen == 0, "R8", "no valid without anchor", seen, 0);
    chk(bit_out == 1'b1, "R1", "bit_out held after reset", bit_out, 1);

    for (int i = 0; i < 7; i++)
      run_window(VEC[i][31], VEC[i][30], VEC[i][28:0], VEC[i][29]);

    // R9: second strobe at cycle 20 restarts the window at cycle 25
    @(negedge clk);
    fixed_bus = 1'b0;
    rx_bit_strobe = 1'b1;
    drive(1'b1, 1'b1);
    seen = 0;
    for (int c = 1; c <= 53; c++) begin
      @(negedge clk);
      rx_bit_strobe = (c == 20);
      drive(c < 25, 1'b1);
      if (bit_valid) seen++;
    end
    @(negedge clk);
    rx_bit_strobe = 1'b0;
    chk(seen == 0, "R9", "dropped window gives no valid", seen, 0);
    chk(bit_valid == 1'b1, "R9", "restarted window valid", bit_valid, 1);
    chk(bit_out == 1'b1, "R9", "count cleared on restart", bit_out, 1);
    repeat (4) @(negedge clk);

    // R1: reset in mid-window drops it
    rx_bit_strobe = 1'b1;
    drive(1'b1, 1'b0);
    @(negedge clk);
    rx_bit_strobe = 1'b0;
    repeat (14) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(bit_valid == 1'b0 && bit_out == 1'b1, "R1", "state in reset",
        {bit_valid, bit_out}, 1);
    rst = 1'b0;
    seen = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (bit_valid) seen++;
    end
    chk(seen == 0, "R1", "no valid after mid-window reset", seen, 0);
    chk(bit_out == 1'b1, "R10", "bit_out unchanged without valid", bit_out, 1);

    // R4/R10: a window after reset still decides correctly
    run_window(1'b1, 1'b0, 29'h1FFFFFFF, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule